// File: doc/BRIEF.md
# Calibration Pattern Readout Responder

This block models the memory side of a read-timing calibration exchange. It watches a one-command-per-cycle command stream, decodes mode register writes, and keeps the three settings that matter for calibration: the pattern-readout enable held in the fourth mode register, the CAS latency and the additive latency. While pattern readout is on, every read is answered with a fixed alternating training pattern. While it is off, reads return bytes from a small internal array that writes fill. The answer is an eight-beat burst that starts a read latency of AL + CL cycles after the read command. The block is synthesizable, so a sequencer under test can be paired with it in simulation or on an emulation platform.

The block also checks the command stream against the rules around mode register writes. A mode register write is illegal while any bank is open. The block enforces minimum spacing after a mode register write. It rejects writes while the pattern source is selected, and it rejects pattern reads that ask for a burst order other than the fixed one. Each rule owns one sticky flag bit.

Three state machines share the work. The readout mode machine has states M_ARRAY and M_PATTERN, and it moves between them only on a write to the fourth mode register. The spacing machine goes from any state to T_MRD on a mode register write. It goes from T_MRD to T_MOD once the MRS-to-MRS gap has passed, and from T_MOD to T_FREE once the MRS-to-command gap has passed. The burst machine goes from B_IDLE to B_RUN when a delayed read reaches the head of the latency line, stays in B_RUN while beats remain or a new read arrives, and goes back to B_IDLE after the eighth beat.

Top module: `patread_resp`

## Requirements
- R1: A mode register write (`cmd_op` = 5) selects its target with `cmd_bank`: 0 loads CL = `CL_BASE` + A[6:4], 1 loads the AL code A[4:3] (00 gives AL = 0, 01 gives AL = CL-1, 10 gives AL = CL-2, 11 gives AL = 0), 3 loads the readout mode, and 2 or any other value changes no setting.
- R2: After a write to target 3, `pat_mode` is 1 only when that write had A2 = 1 and A[1:0] = 00; any other value written to target 3 makes it 0.
- R3: A read (`cmd_op` = 3) issued at clock edge E makes `rd_valid` high for exactly eight consecutive cycles, starting after edge E + AL + CL.
- R4: In pattern mode the eight beats are, in order, all-zero, all-one, alternating, so `rd_data` is 8'h00 on even beats and 8'hFF on odd beats.
- R5: In array mode a write (`cmd_op` = 4) stores `wr_data` at index {bank, A[1:0]}, and a later read of that index returns the stored byte on all eight beats.
- R6: Activate (`cmd_op` = 1) opens the addressed bank. Precharge (`cmd_op` = 2) closes the addressed bank, or all banks when A10 = 1. A mode register write while any bank is open sets `viol[0]`.
- R7: A mode register write fewer than `TMRD` cycles after the previous one, or any activate, precharge, read or write fewer than `TMOD` cycles after a mode register write, sets `viol[1]`. Exactly `TMRD` or `TMOD` cycles is legal.
- R8: A write in pattern mode sets `viol[2]` and leaves the array unchanged.
- R9: A read in pattern mode with A[2:0] other than 000 sets `viol[3]`. The burst is still the pattern.
- R10: Violation bits stay set until `clr_viol` is high at a clock edge. A violation detected at that same edge is set, not cleared.
- R11: Reset clears all flags, closes all banks, selects array mode with CL = `CL_BASE` and AL = 0, frees the spacing timer and drops `rd_valid`. The array contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_op | input | 3 | Command: 0 none, 1 activate, 2 precharge, 3 read, 4 write, 5 mode register write; 6 and 7 act as none |
| cmd_bank | input | $clog2(NBANK) | Bank address, or mode register target |
| cmd_addr | input | 14 | Address bus: A[1:0] column and burst start, A2 burst order, A10 all-bank precharge, low bits carry mode register fields |
| wr_data | input | DW | Byte stored by an array-mode write |
| clr_viol | input | 1 | Clears the sticky violation flags |
| rd_valid | output | 1 | A read beat is on `rd_data` |
| rd_data | output | DW | Read beat |
| pat_mode | output | 1 | Pattern readout is selected |
| viol | output | 4 | Sticky flags: bit 0 mode write with bank open, bit 1 spacing, bit 2 write in pattern mode, bit 3 bad pattern read address |

## Verification
Clearing the flags and detecting a new violation can happen in the same cycle. This is the case where a wrong priority hides errors. The stimulus table drives `clr_viol` together with a violating command: a write in pattern mode while the spacing flag is already set, then misaligned pattern reads while the write flag is set. Each of these rows expects only the bit belonging to the new violation to survive. The table also places commands exactly at and just inside the `TMRD` and `TMOD` limits, and the directed tests measure the first beat of each burst against AL + CL for several latency settings.

// File: rtl/patread_pkg.sv
package patread_pkg;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_PRE = 3'd2,
        OP_RD  = 3'd3,
        OP_WR  = 3'd4,
        OP_MRS = 3'd5
    } cmd_op_e;

    localparam int V_OPEN  = 0;
    localparam int V_TIME  = 1;
    localparam int V_WRPAT = 2;
    localparam int V_ADDR  = 3;
    localparam int NVIOL   = 4;

    typedef enum logic [1:0] {T_FREE, T_MRD, T_MOD} tgap_e;
    typedef enum logic {M_ARRAY, M_PATTERN} rmode_e;
    typedef enum logic {B_IDLE, B_RUN} burst_e;

endpackage

// File: rtl/patread_modereg.sv
module patread_modereg
    import patread_pkg::*;
#(
    parameter int BANKW   = 3,
    parameter int CL_BASE = 5,
    parameter int RLW     = 5,
    parameter int TMRD    = 4,
    parameter int TMOD    = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_op_e          op,
    input  logic [BANKW-1:0] bank,
    input  logic [6:0]       a_lo,
    output logic             pat_mode,
    output logic [RLW-1:0]   rl,
    output logic             early_mrs,
    output logic             early_cmd
);
    localparam int CNTW = $clog2(TMOD + 1);

    rmode_e          mode_q, mode_d;
    tgap_e           gap_q, gap_d;
    logic [CNTW-1:0] cnt_q, cnt_d;
    logic [2:0]      cl_code_q;
    logic [1:0]      al_sel_q;
    logic            is_mrs, to_mr0, to_mr1, to_mr3, real_cmd;
    logic [RLW-1:0]  cl, al;

    assign is_mrs   = (op == OP_MRS);
    assign to_mr0   = is_mrs && (bank == BANKW'(0));
    assign to_mr1   = is_mrs && (bank == BANKW'(1));
    assign to_mr3   = is_mrs && (bank == BANKW'(3));
    assign real_cmd = (op == OP_ACT) || (op == OP_PRE) || (op == OP_RD) || (op == OP_WR);

    // next-state logic for readout mode and spacing timer
    always_comb begin
        mode_d = mode_q;
        if (to_mr3) begin
            mode_d = (a_lo[2] && (a_lo[1:0] == 2'b00)) ? M_PATTERN : M_ARRAY;
        end
        gap_d = gap_q;
        cnt_d = cnt_q;
        if (is_mrs) begin
            gap_d = T_MRD;
            cnt_d = CNTW'(1);
        end else begin
            unique case (gap_q)
                T_FREE: begin
                    gap_d = T_FREE;
                end
                T_MRD: begin
                    cnt_d = cnt_q + CNTW'(1);
                    if (cnt_q + CNTW'(1) == CNTW'(TMRD)) gap_d = T_MOD;
                end
                T_MOD: begin
                    cnt_d = cnt_q + CNTW'(1);
                    if (cnt_q + CNTW'(1) == CNTW'(TMOD)) gap_d = T_FREE;
                end
                default: gap_d = T_FREE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q    <= M_ARRAY;
            gap_q     <= T_FREE;
            cnt_q     <= '0;
            cl_code_q <= '0;
            al_sel_q  <= '0;
        end else begin
            mode_q <= mode_d;
            gap_q  <= gap_d;
            cnt_q  <= cnt_d;
            if (to_mr0) cl_code_q <= a_lo[6:4];
            if (to_mr1) al_sel_q  <= a_lo[4:3];
        end
    end

    // outputs
    always_comb begin
        pat_mode  = (mode_q == M_PATTERN);
        early_mrs = is_mrs && (gap_q == T_MRD);
        early_cmd = real_cmd && (gap_q != T_FREE);
        cl        = RLW'(CL_BASE) + RLW'(cl_code_q);
        unique case (al_sel_q)
            2'd1:    al = cl - RLW'(1);
            2'd2:    al = cl - RLW'(2);
            default: al = '0;
        endcase
        rl = cl + al;
    end

    // R2
    mr3_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (to_mr3 && a_lo[2:0] == 3'b100) |=> pat_mode);

    // R2
    mr3_leave_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (to_mr3 && a_lo[2:0] != 3'b100) |=> !pat_mode);

endmodule

// File: rtl/patread_bank_track.sv
module patread_bank_track
    import patread_pkg::*;
#(
    parameter int NBANK = 8,
    parameter int BANKW = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_op_e          op,
    input  logic [BANKW-1:0] bank,
    input  logic             all_banks,
    output logic             any_open
);
    logic [NBANK-1:0] open_q, open_d;

    always_comb begin
        open_d = open_q;
        for (int i = 0; i < NBANK; i++) begin
            if (op == OP_ACT && bank == BANKW'(i)) begin
                open_d[i] = 1'b1;
            end else if (op == OP_PRE && (all_banks || bank == BANKW'(i))) begin
                open_d[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) open_q <= '0;
        else        open_q <= open_d;
    end

    assign any_open = |open_q;

    // R6
    act_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_ACT) |=> any_open);

    // R6
    prea_close_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_PRE && all_banks) |=> !any_open);

endmodule

// File: rtl/patread_rd_pipe.sv
module patread_rd_pipe
    import patread_pkg::*;
#(
    parameter int DW     = 8,
    parameter int NBANK  = 8,
    parameter int BANKW  = 3,
    parameter int COLW   = 2,
    parameter int RLW    = 5,
    parameter int RL_MAX = 23
) (
    input  logic             clk,
    input  logic             rst_n,
    input  cmd_op_e          op,
    input  logic [BANKW-1:0] bank,
    input  logic [COLW-1:0]  col,
    input  logic [DW-1:0]    wr_data,
    input  logic             pat_mode,
    input  logic [RLW-1:0]   rl,
    output logic             rd_valid,
    output logic [DW-1:0]    rd_data
);
    localparam int DEPTH = NBANK << COLW;
    localparam int BURST = 8;
    localparam int BEATW = $clog2(BURST);

    typedef struct packed {
        logic          vld;
        logic          pat;
        logic [DW-1:0] word;
    } slot_t;

    localparam int SW = $bits(slot_t);

    logic [DW-1:0]              mem_q [DEPTH];
    slot_t [RL_MAX-1:0]         line_q, line_d;
    slot_t                      ins, head;
    burst_e                     bst_q, bst_d;
    logic [BEATW-1:0]           beat_q;
    logic                       hold_pat_q;
    logic [DW-1:0]              hold_word_q;
    logic [BANKW+COLW-1:0]      idx;

    assign idx = {bank, col};

    // array storage; writes in pattern mode are dropped
    always_ff @(posedge clk) begin
        if (op == OP_WR && !pat_mode) mem_q[idx] <= wr_data;
    end

    // latency line: each read lands RL-1 slots from the head
    always_comb begin
        ins.vld  = 1'b1;
        ins.pat  = pat_mode;
        ins.word = mem_q[idx];
        line_d   = line_q >> SW;
        if (op == OP_RD) line_d[rl - RLW'(1)] = ins;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) line_q <= '0;
        else        line_q <= line_d;
    end

    assign head = line_q[0];

    // burst next state
    always_comb begin
        bst_d = bst_q;
        unique case (bst_q)
            B_IDLE: if (head.vld) bst_d = B_RUN;
            B_RUN:  if (!head.vld && beat_q == BEATW'(BURST - 1)) bst_d = B_IDLE;
            default: bst_d = B_IDLE;
        endcase
    end

    // burst state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bst_q       <= B_IDLE;
            beat_q      <= '0;
            hold_pat_q  <= 1'b0;
            hold_word_q <= '0;
        end else begin
            bst_q <= bst_d;
            if (head.vld) begin
                beat_q      <= '0;
                hold_pat_q  <= head.pat;
                hold_word_q <= head.word;
            end else if (bst_q == B_RUN) begin
                beat_q <= beat_q + BEATW'(1);
            end
        end
    end

    // burst outputs
    always_comb begin
        unique case (bst_q)
            B_RUN: begin
                rd_valid = 1'b1;
                rd_data  = hold_pat_q ? {DW{beat_q[0]}} : hold_word_q;
            end
            default: begin
                rd_valid = 1'b0;
                rd_data  = '0;
            end
        endcase
    end

    // R3
    burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && beat_q != BEATW'(BURST - 1)) |=> rd_valid);

    // R3
    burst_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        head.vld |=> (rd_valid && beat_q == '0));

    // R4
    pattern_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && $past(rd_valid) && hold_pat_q && beat_q != '0)
        |-> (rd_data == ~$past(rd_data)));

endmodule

// File: rtl/patread_resp.sv
module patread_resp
    import patread_pkg::*;
#(
    parameter int DW      = 8,
    parameter int NBANK   = 8,
    parameter int COLW    = 2,
    parameter int CL_BASE = 5,
    parameter int TMRD    = 4,
    parameter int TMOD    = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [2:0]               cmd_op,
    input  logic [$clog2(NBANK)-1:0] cmd_bank,
    input  logic [13:0]              cmd_addr,
    input  logic [DW-1:0]            wr_data,
    input  logic                     clr_viol,
    output logic                     rd_valid,
    output logic [DW-1:0]            rd_data,
    output logic                     pat_mode,
    output logic [NVIOL-1:0]         viol
);
    localparam int BANKW  = $clog2(NBANK);
    localparam int RL_MAX = 2 * (CL_BASE + 7) - 1;
    localparam int RLW    = $clog2(RL_MAX + 1);

    cmd_op_e          op;
    logic [RLW-1:0]   rl;
    logic             early_mrs, early_cmd, any_open;
    logic [NVIOL-1:0] viol_q, viol_new;
    logic             unused_addr_bits;

    assign op               = cmd_op_e'(cmd_op);
    assign unused_addr_bits = ^{cmd_addr[13:11], cmd_addr[9:7]};

    patread_modereg #(
        .BANKW(BANKW), .CL_BASE(CL_BASE), .RLW(RLW), .TMRD(TMRD), .TMOD(TMOD)
    ) u_modereg (
        .clk(clk), .rst_n(rst_n), .op(op), .bank(cmd_bank), .a_lo(cmd_addr[6:0]),
        .pat_mode(pat_mode), .rl(rl), .early_mrs(early_mrs), .early_cmd(early_cmd)
    );

    patread_bank_track #(
        .NBANK(NBANK), .BANKW(BANKW)
    ) u_banks (
        .clk(clk), .rst_n(rst_n), .op(op), .bank(cmd_bank),
        .all_banks(cmd_addr[10]), .any_open(any_open)
    );

    patread_rd_pipe #(
        .DW(DW), .NBANK(NBANK), .BANKW(BANKW), .COLW(COLW), .RLW(RLW), .RL_MAX(RL_MAX)
    ) u_rdpipe (
        .clk(clk), .rst_n(rst_n), .op(op), .bank(cmd_bank), .col(cmd_addr[COLW-1:0]),
        .wr_data(wr_data), .pat_mode(pat_mode), .rl(rl),
        .rd_valid(rd_valid), .rd_data(rd_data)
    );

    always_comb begin
        viol_new          = '0;
        viol_new[V_OPEN]  = (op == OP_MRS) && any_open;
        viol_new[V_TIME]  = early_mrs || early_cmd;
        viol_new[V_WRPAT] = (op == OP_WR) && pat_mode;
        viol_new[V_ADDR]  = (op == OP_RD) && pat_mode && (cmd_addr[2:0] != 3'b000);
    end

    // a fresh violation outranks a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) viol_q <= '0;
        else        viol_q <= (clr_viol ? '0 : viol_q) | viol_new;
    end

    assign viol = viol_q;

    // R6
    open_mrs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_MRS && any_open) |=> viol[V_OPEN]);

    // R7
    mrs_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_MRS && $past(op) == OP_MRS) |=> viol[V_TIME]);

    // R8
    wr_pat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_WR && pat_mode) |=> viol[V_WRPAT]);

    // R9
    rd_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_RD && pat_mode && cmd_addr[2:0] != 3'b000) |=> viol[V_ADDR]);

    // R10
    sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_viol |=> ((viol & $past(viol)) == $past(viol)));

endmodule

// File: tb/test_patread_resp.sv
`timescale 1ns/1ps
module test_patread_resp;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [2:0]  cmd_op;
    logic [2:0]  cmd_bank;
    logic [13:0] cmd_addr;
    logic [7:0]  wr_data;
    logic        clr_viol;
    logic        rd_valid;
    logic [7:0]  rd_data;
    logic        pat_mode;
    logic [3:0]  viol;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    patread_resp i_patread_resp (
        .clk(clk), .rst_n(rst_n), .cmd_op(cmd_op), .cmd_bank(cmd_bank),
        .cmd_addr(cmd_addr), .wr_data(wr_data), .clr_viol(clr_viol),
        .rd_valid(rd_valid), .rd_data(rd_data), .pat_mode(pat_mode), .viol(viol)
    );

    // row: gap[29:26] op[25:23] bank[22:20] addr[19:6] clr[5] exp_viol[4:1] exp_pat[0]
    localparam int NROW = 18;
    localparam logic [29:0] VEC [NROW] = '{
        {4'd0,  3'd1, 3'd2, 14'h000, 1'b0, 4'b0000, 1'b0},  // R6 open bank 2
        {4'd0,  3'd5, 3'd3, 14'h000, 1'b0, 4'b0001, 1'b0},  // R6 mode write, bank open
        {4'd12, 3'd2, 3'd2, 14'h000, 1'b1, 4'b0000, 1'b0},  // R10 clear, close bank 2
        {4'd0,  3'd5, 3'd3, 14'h004, 1'b0, 4'b0000, 1'b1},  // R2 enter pattern
        {4'd1,  3'd5, 3'd0, 14'h000, 1'b0, 4'b0010, 1'b1},  // R7 MRS gap 2
        {4'd3,  3'd3, 3'd0, 14'h000, 1'b0, 4'b0010, 1'b1},  // R7 read gap 4
        {4'd12, 3'd4, 3'd0, 14'h000, 1'b1, 4'b0100, 1'b1},  // R8 + R10 clear with new
        {4'd0,  3'd3, 3'd0, 14'h001, 1'b1, 4'b1000, 1'b1},  // R9 A0 set
        {4'd0,  3'd3, 3'd0, 14'h004, 1'b1, 4'b1000, 1'b1},  // R9 A2 set
        {4'd0,  3'd5, 3'd3, 14'h000, 1'b1, 4'b0000, 1'b0},  // R2 leave pattern
        {4'd3,  3'd5, 3'd1, 14'h000, 1'b0, 4'b0000, 1'b0},  // R7 MRS gap exactly TMRD
        {4'd10, 3'd1, 3'd0, 14'h000, 1'b0, 4'b0010, 1'b0},  // R7 command gap TMOD-1
        {4'd11, 3'd2, 3'd0, 14'h400, 1'b1, 4'b0000, 1'b0},  // R6 precharge all
        {4'd0,  3'd5, 3'd0, 14'h000, 1'b0, 4'b0000, 1'b0},  // R6 MRS all closed
        {4'd11, 3'd1, 3'd1, 14'h000, 1'b0, 4'b0000, 1'b0},  // R7 command gap exactly TMOD
        {4'd0,  3'd5, 3'd2, 14'h000, 1'b0, 4'b0001, 1'b0},  // R1 target 2, R6 bank 1 open
        {4'd12, 3'd2, 3'd0, 14'h400, 1'b1, 4'b0000, 1'b0},  // R6 close all
        {4'd12, 3'd5, 3'd3, 14'h005, 1'b0, 4'b0000, 1'b0}   // R2 A2 with A0 set stays off
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [2:0] op, input logic [2:0] bank,
                         input logic [13:0] addr, input logic [7:0] wd, input logic clr);
        cmd_op   = op;
        cmd_bank = bank;
        cmd_addr = addr;
        wr_data  = wd;
        clr_viol = clr;
        @(negedge clk);
        cmd_op   = 3'd0;
        cmd_bank = 3'd0;
        cmd_addr = 14'h0;
        wr_data  = 8'h0;
        clr_viol = 1'b0;
    endtask

    task automatic nops(input int n);
        repeat (n) drive(3'd0, 3'd0, 14'h0, 8'h0, 1'b0);
    endtask

    task automatic read_burst(input string req, input logic [2:0] bank, input logic [13:0] addr,
                              input int rl, input logic pat, input logic [7:0] word);
        drive(3'd3, bank, addr, 8'h0, 1'b0);
        nops(rl - 1);
        chk({req, " early"}, {31'd0, rd_valid}, 32'd0);
        nops(1);
        for (int b = 0; b < 8; b++) begin
            chk({req, " valid"}, {31'd0, rd_valid}, 32'd1);
            chk({req, " data"}, {24'd0, rd_data},
                pat ? ((b % 2 == 1) ? 32'hFF : 32'h00) : {24'd0, word});
            nops(1);
        end
        chk({req, " end"}, {31'd0, rd_valid}, 32'd0);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n    = 1'b0;
        cmd_op   = 3'd0;
        cmd_bank = 3'd0;
        cmd_addr = 14'h0;
        wr_data  = 8'h0;
        clr_viol = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk("R11 flags", {28'd0, viol}, 32'd0);
        chk("R11 mode", {31'd0, pat_mode}, 32'd0);
        chk("R11 valid", {31'd0, rd_valid}, 32'd0);

        for (int i = 0; i < NROW; i++) begin
            nops(int'(VEC[i][29:26]));
            drive(VEC[i][25:23], VEC[i][22:20], VEC[i][19:6], 8'h0, VEC[i][5]);
            chk($sformatf("R6/R7/R8/R9/R10 flags row %0d", i), {28'd0, viol}, {28'd0, VEC[i][4:1]});
            chk($sformatf("R2 mode row %0d", i), {31'd0, pat_mode}, {31'd0, VEC[i][0]});
        end

        // R5 array write then read, RL = 5
        nops(12);
        drive(3'd4, 3'd3, 14'h002, 8'hA5, 1'b0);
        chk("R5 write flags", {28'd0, viol}, 32'd0);
        read_burst("R5 array read", 3'd3, 14'h002, 5, 1'b0, 8'hA5);

        // R4 pattern burst, R8 write dropped
        drive(3'd5, 3'd3, 14'h004, 8'h0, 1'b0);
        nops(12);
        chk("R2 pattern on", {31'd0, pat_mode}, 32'd1);
        drive(3'd4, 3'd3, 14'h002, 8'h3C, 1'b0);
        chk("R8 write flag", {28'd0, viol}, 32'h4);
        drive(3'd0, 3'd0, 14'h0, 8'h0, 1'b1);
        chk("R10 clear", {28'd0, viol}, 32'd0);
        read_burst("R4 pattern", 3'd3, 14'h000, 5, 1'b1, 8'h00);
        chk("R9 legal address", {28'd0, viol}, 32'd0);
        drive(3'd5, 3'd3, 14'h000, 8'h0, 1'b0);
        nops(12);
        read_burst("R8 array unchanged", 3'd3, 14'h002, 5, 1'b0, 8'hA5);

        // R1 latency settings: CL = 7
        drive(3'd5, 3'd0, 14'h020, 8'h0, 1'b0);
        nops(4);
        drive(3'd5, 3'd1, 14'h008, 8'h0, 1'b0);
        nops(12);
        chk("R7 spacing legal", {28'd0, viol}, 32'd0);
        read_burst("R1 AL=CL-1", 3'd3, 14'h002, 13, 1'b0, 8'hA5);
        drive(3'd5, 3'd1, 14'h010, 8'h0, 1'b0);
        nops(12);
        read_burst("R1 AL=CL-2", 3'd3, 14'h002, 12, 1'b0, 8'hA5);
        drive(3'd5, 3'd1, 14'h018, 8'h0, 1'b0);
        nops(12);
        read_burst("R1 AL code 3", 3'd3, 14'h002, 7, 1'b0, 8'hA5);

        // R11 reset mid-run restores defaults
        drive(3'd5, 3'd3, 14'h004, 8'h0, 1'b0);
        drive(3'd1, 3'd4, 14'h000, 8'h0, 1'b0);
        chk("R7 early activate", {28'd0, viol}, 32'h2);
        rst_n = 1'b0;
        nops(2);
        rst_n = 1'b1;
        chk("R11 flags after reset", {28'd0, viol}, 32'd0);
        chk("R11 mode after reset", {31'd0, pat_mode}, 32'd0);
        drive(3'd5, 3'd2, 14'h000, 8'h0, 1'b0);
        chk("R11 banks closed", {28'd0, viol}, 32'd0);
        nops(12);
        read_burst("R11 default latency", 3'd3, 14'h002, 5, 1'b0, 8'hA5);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule